// File: doc/BRIEF.md
# Synchronous FIFO with status flags

This block is a single-clock first-in first-out buffer. Its data width and depth are parameters, 16 bits and 8 entries by default. A producer offers a word together with a write request. A consumer raises a read request and finds the oldest stored word on a registered output after the next clock edge. An active-low asynchronous reset empties the buffer.

Besides full and empty, the block reports two threshold flags. The near-full flag marks one free slot left, and the near-empty flag marks one stored word left. Each request also produces a one-cycle indication on the edge after it. A successful write raises an acknowledge. A write refused for lack of room raises an overflow pulse, and a read refused for lack of data raises an underflow pulse. When both requests arrive together on an empty buffer, only the write takes place. On a full buffer, only the read takes place. Anywhere in between, both take place in the same cycle.

Top module: `fifo_sync_stat`

## Requirements
- R1: While `rst_n` is low, `empty` is 1. `full`, `near_full`, `near_empty`, `wr_ack`, `overflow` and `underflow` are 0, and `rd_data` is 0.
- R2: Words leave in the order they were accepted. `rd_data` takes the oldest stored word on the edge that accepts a read and holds its value on every other edge.
- R3: A write request seen while `full` is 1 stores nothing. `overflow` is 1 for exactly the cycle after that edge and 0 after any edge without a refused write.
- R4: A read request seen while `empty` is 1 removes nothing and leaves `rd_data` unchanged. `underflow` is 1 for exactly the cycle after that edge.
- R5: `wr_ack` is 1 in the cycle after an edge on which a write was accepted, and 0 otherwise.
- R6: `full` is 1 exactly when DEPTH words are stored. `empty` is 1 exactly when none are stored.
- R7: `near_full` is 1 exactly when DEPTH-1 words are stored.
- R8: `near_empty` is 1 exactly when one word is stored.
- R9: Read and write requested together while empty: only the write is performed. The buffer then holds one word, `wr_ack` and `underflow` are both 1, and `rd_data` is unchanged.
- R10: Read and write requested together while full: only the read is performed. The buffer then holds DEPTH-1 words, `overflow` is 1, `wr_ack` is 0, and the incoming word is discarded.
- R11: Read and write requested together while neither empty nor full: both are performed, and the stored count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_data | input | WIDTH | Word offered for storage |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| rd_data | output | WIDTH | Registered word delivered by the last accepted read |
| full | output | 1 | DEPTH words stored |
| near_full | output | 1 | DEPTH-1 words stored |
| empty | output | 1 | No word stored |
| near_empty | output | 1 | One word stored |
| overflow | output | 1 | Write refused on the previous edge |
| underflow | output | 1 | Read refused on the previous edge |
| wr_ack | output | 1 | Write accepted on the previous edge |

## Verification
A wrong occupancy count shows up at the ports on the very next edge. The four level flags would disagree with the count of accepted writes minus accepted reads, and the acknowledge and refusal pulses would then follow the wrong boundary. A wrong read or write pointer leaves the flags correct. It only shows up as a word out of order or stale on `rd_data`, and that may take up to DEPTH further reads to appear. The scoreboard therefore compares every delivered word and every flag on every cycle, through repeated fill, drain and wrap-around sequences.

// File: rtl/fifo_stat_pkg.sv
package fifo_stat_pkg;

  // Occupancy-derived status, produced by the flag unit.
  typedef struct packed {
    logic full;
    logic empty;
    logic near_full;
    logic near_empty;
  } lvl_flags_t;

endpackage

// File: rtl/fifo_stat_ctrl.sv
module fifo_stat_ctrl #(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          is_full,
  input  logic          is_empty,
  output logic          wr_go,
  output logic          rd_go,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [CW-1:0] level
);

  localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

  // Pointer advance with wrap at DEPTH-1 (depth need not be a power of two).
  function automatic logic [AW-1:0] bump_ptr(input logic [AW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + AW'(1);
  endfunction

  // New occupancy after one edge.
  function automatic logic [CW-1:0] next_level(input logic [CW-1:0] cur,
                                              input logic w, input logic r);
    case ({w, r})
      2'b10:   return cur + CW'(1);
      2'b01:   return cur - CW'(1);
      default: return cur;
    endcase
  endfunction

  // Acceptance: a write needs room, a read needs data. On an empty buffer
  // this leaves only the write; on a full one only the read.
  assign wr_go = wr_req && !is_full;
  assign rd_go = rd_req && !is_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_go) wr_ptr <= bump_ptr(wr_ptr);
      if (rd_go) rd_ptr <= bump_ptr(rd_ptr);
      level <= next_level(level, wr_go, rd_go);
    end
  end

endmodule

// File: rtl/fifo_stat_store.sv
module fifo_stat_store #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // Registered read port: changes only on an accepted read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= cells[raddr];
  end

endmodule

// File: rtl/fifo_stat_flags.sv
module fifo_stat_flags
  import fifo_stat_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] level,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          wr_go,
  output lvl_flags_t    lvl,
  output logic          overflow,
  output logic          underflow,
  output logic          wr_ack
);

  localparam logic [CW-1:0] TOP_LVL  = CW'(DEPTH);
  localparam logic [CW-1:0] NEAR_TOP = CW'(DEPTH - 1);
  localparam logic [CW-1:0] ONE_LVL  = CW'(1);

  function automatic lvl_flags_t decode_level(input logic [CW-1:0] n);
    lvl_flags_t f;
    f.full       = (n == TOP_LVL);
    f.empty      = (n == '0);
    f.near_full  = (n == NEAR_TOP);
    f.near_empty = (n == ONE_LVL);
    return f;
  endfunction

  assign lvl = decode_level(level);

  // One-cycle indications for the request of the previous edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow  <= 1'b0;
      underflow <= 1'b0;
      wr_ack    <= 1'b0;
    end else begin
      overflow  <= wr_req && lvl.full;
      underflow <= rd_req && lvl.empty;
      wr_ack    <= wr_go;
    end
  end

endmodule

// File: rtl/fifo_sync_stat.sv
module fifo_sync_stat
  import fifo_stat_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_req,
  input  logic             rd_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             near_full,
  output logic             empty,
  output logic             near_empty,
  output logic             overflow,
  output logic             underflow,
  output logic             wr_ack
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  // Internal events, named for the checker.
  logic          acc_wr;
  logic          acc_rd;
  logic [AW-1:0] wptr;
  logic [AW-1:0] rptr;
  logic [CW-1:0] level;
  lvl_flags_t    lvl;

  fifo_stat_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .is_full  (lvl.full),
    .is_empty (lvl.empty),
    .wr_go    (acc_wr),
    .rd_go    (acc_rd),
    .wr_ptr   (wptr),
    .rd_ptr   (rptr),
    .level    (level)
  );

  fifo_stat_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (acc_wr),
    .waddr (wptr),
    .wdata (wr_data),
    .re    (acc_rd),
    .raddr (rptr),
    .rdata (rd_data)
  );

  fifo_stat_flags #(.DEPTH(DEPTH)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (level),
    .wr_req    (wr_req),
    .rd_req    (rd_req),
    .wr_go     (acc_wr),
    .lvl       (lvl),
    .overflow  (overflow),
    .underflow (underflow),
    .wr_ack    (wr_ack)
  );

  assign full       = lvl.full;
  assign empty      = lvl.empty;
  assign near_full  = lvl.near_full;
  assign near_empty = lvl.near_empty;

endmodule

// File: rtl/fifo_sync_stat_chk.sv
module fifo_sync_stat_chk #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_req,
  input logic             rd_req,
  input logic [WIDTH-1:0] rd_data,
  input logic             full,
  input logic             near_full,
  input logic             empty,
  input logic             near_empty,
  input logic             overflow,
  input logic             underflow,
  input logic             wr_ack,
  input logic             acc_wr,
  input logic             acc_rd,
  input logic [CW-1:0]    level
);

  // R1: reset state
  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |-> (empty && !full && !near_full && !near_empty &&
                !overflow && !underflow && !wr_ack));

  // R2: output holds without an accepted read
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rd_data));

  // R3: refused write gives overflow and no acknowledge
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req) |=> (overflow && !wr_ack));

  // R4: refused read gives underflow and leaves the output
  p_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_req) |=> (underflow && $stable(rd_data)));

  // R5: accepted write is acknowledged
  p_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_wr |=> wr_ack);

  // R6: full and empty never together
  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  // R7: a lone write at near-full fills the buffer
  p_near_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (near_full && acc_wr && !acc_rd) |=> full);

  // R8: a lone read at near-empty empties the buffer
  p_near_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (near_empty && acc_rd && !acc_wr) |=> empty);

  // R9: both requests on empty performs the write only
  p_both_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_req && rd_req) |=> (near_empty && wr_ack && underflow));

  // R10: both requests on full performs the read only
  p_both_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_req && rd_req) |=> (near_full && overflow && !wr_ack));

  // R11: simultaneous accepted read and write keep the count
  p_both_mid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && acc_rd) |=> $stable(level));

endmodule

bind fifo_sync_stat fifo_sync_stat_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_req     (wr_req),
  .rd_req     (rd_req),
  .rd_data    (rd_data),
  .full       (full),
  .near_full  (near_full),
  .empty      (empty),
  .near_empty (near_empty),
  .overflow   (overflow),
  .underflow  (underflow),
  .wr_ack     (wr_ack),
  .acc_wr     (acc_wr),
  .acc_rd     (acc_rd),
  .level      (level)
);

// File: tb/sim_fifo_sync_stat.sv
`timescale 1ns/1ps
module sim_fifo_sync_stat;

  localparam int W = 16;
  localparam int D = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         wr_req = 1'b0;
  logic         rd_req = 1'b0;
  logic [W-1:0] rd_data;
  logic         full, near_full, empty, near_empty;
  logic         overflow, underflow, wr_ack;

  always #2.5 clk = ~clk;   // 200 MHz

  fifo_sync_stat #(.WIDTH(W), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_req(wr_req),
    .rd_req(rd_req), .rd_data(rd_data), .full(full), .near_full(near_full),
    .empty(empty), .near_empty(near_empty), .overflow(overflow),
    .underflow(underflow), .wr_ack(wr_ack)
  );

  typedef struct {
    logic [W-1:0] d;
    bit f, e, nf, ne, ov, ud, ak;
    string tag;
  } exp_t;

  exp_t         exp_q[$];
  logic [W-1:0] mdl[$];
  logic [W-1:0] last_out = '0;
  int           n_run = 0;
  int           n_fail = 0;
  bit           done = 0;

  task automatic chk(input string req, input string tag,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s): actual %0h expected %0h", req, tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of requests and pushes the expected result.
  task automatic step(input bit w, input bit r, input logic [W-1:0] d,
                      input string tag);
    exp_t e;
    int   cnt;
    bit   wa, ra;
    @(negedge clk);
    wr_req = w; rd_req = r; wr_data = d;
    cnt = mdl.size();
    wa = w && (cnt < D);
    ra = r && (cnt > 0);
    e.ov = w && (cnt == D);
    e.ud = r && (cnt == 0);
    e.ak = wa;
    if (ra) last_out = mdl.pop_front();
    if (wa) mdl.push_back(d);
    cnt = mdl.size();
    e.d  = last_out;
    e.f  = (cnt == D);
    e.e  = (cnt == 0);
    e.nf = (cnt == D - 1);
    e.ne = (cnt == 1);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compares each expected item just after its edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        e = exp_q.pop_front();
        chk("R2",  e.tag, rd_data, e.d);
        chk("R6",  e.tag, {15'b0, full},  {15'b0, e.f});
        chk("R6",  e.tag, {15'b0, empty}, {15'b0, e.e});
        chk("R7",  e.tag, {15'b0, near_full},  {15'b0, e.nf});
        chk("R8",  e.tag, {15'b0, near_empty}, {15'b0, e.ne});
        chk("R3",  e.tag, {15'b0, overflow},  {15'b0, e.ov});
        chk("R4",  e.tag, {15'b0, underflow}, {15'b0, e.ud});
        chk("R5",  e.tag, {15'b0, wr_ack},    {15'b0, e.ak});
      end
    end
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values
    chk("R1", "reset", rd_data, '0);
    chk("R1", "reset", {9'b0, empty, full, near_full, near_empty, overflow,
                        underflow, wr_ack}, 16'h0040);
    rst_n = 1'b1;

    step(0, 1, 16'h0, "R4 read on empty");
    step(0, 0, 16'h0, "idle");
    for (int i = 0; i < D; i++) step(1, 0, 16'hA000 + 16'(i), "R5 fill R7");
    step(1, 0, 16'hBEEF, "R3 write on full");
    step(0, 0, 16'h0, "idle");
    step(1, 1, 16'hDEAD, "R10 both on full");
    step(1, 0, 16'hC000, "refill");
    for (int i = 0; i < D + 1; i++) step(0, 1, 16'h0, "R2 drain R8");
    step(1, 1, 16'h1234, "R9 both on empty");
    step(1, 0, 16'h2345, "grow");
    step(1, 0, 16'h3456, "grow");
    step(1, 1, 16'h4567, "R11 both mid");
    step(1, 1, 16'h5678, "R11 both mid");
    for (int i = 0; i < 5; i++) step(0, 1, 16'h0, "R2 drain");
    lf = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0] | (lf[5] & (i < 200)), lf[3] | (lf[7] & (i >= 200)),
           lf ^ 16'(i), "mix R2 R11");
    end
    for (int i = 0; i < D + 2; i++) step(0, 1, 16'h0, "final drain");
    step(0, 0, 16'h0, "idle");
    repeat (4) @(posedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule